// File: doc/BRIEF.md
# PHY power-up and power-down sequencer

This block is a timed state machine that owns five control bits of a high-speed serial PHY and walks them through a fixed bring-up order and a fixed shutdown order. A start request pulses the PHY reset for a fixed time and then releases it. In a separate step it selects the reference source: the pad when an external crystal is present, the internal path when it is not. It then waits for the reference clock to settle and finally turns on the PHY and the lane-0 power-present indication together. A stop request undoes this in three single-cycle steps and leaves the PHY in its retention (power-down) state.

The five bits are exported inside a wider control word at fixed positions. The remaining bits carry a constant parameter value. All delays are given in microseconds and turned into cycles through a cycles-per-microsecond parameter, so a bench can shrink them. Both long waits share one down-counter. Status outputs show when the PHY is up (ready) and when a sequence is in progress (busy).

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset the control word equals CTRL_BASE with bits 28, 27, 24, 8 and 7 all zero, and ready and busy are low.
- R2: A start request seen in the idle state sets PHY reset (bit 7) and clears power-down (bit 27) at the next clock edge, raises busy, and holds bit 7 high for exactly RST_US*CYC_PER_US cycles.
- R3: PHY reset is released in a step of its own. One cycle later the reference-pad select (bit 28) takes the value of xtal_present: 1 with a crystal, 0 without.
- R4: Exactly SETTLE_US*CYC_PER_US cycles after the reference-select step, PHY enable (bit 8) and lane-0 power-present (bit 24) rise in the same cycle.
- R5: ready rises in the same cycle as PHY enable, and busy falls there. ready is never high while busy is high or while enable is low.
- R6: A stop request seen while ready clears ready, PHY enable and power-present at the next edge. It clears the reference-pad select one cycle later and sets power-down (bit 27) one cycle after that, when busy falls. The PHY enable bit is always low before the pad select falls.
- R7: A start or stop request that arrives while busy is high is ignored. A stop request in the idle state and a start request while ready are also ignored. No control bit and no status output changes in response.
- R8: Every bit of the control word other than 28, 27, 24, 8 and 7 equals the matching bit of CTRL_BASE at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to run the bring-up order |
| stop_req | input | 1 | Request to run the shutdown order |
| xtal_present | input | 1 | High when an external crystal reference exists |
| ctrl_word | output | WORD_W | PHY control word (bits 28, 27, 24, 8, 7 driven by the sequencer) |
| ready | output | 1 | PHY enabled and powered |
| busy | output | 1 | A bring-up or shutdown order is in progress |

## Verification
The bench predicts every change of the control word and status outputs, together with the cycle in which it happens, and flags any change it did not predict. Off-by-one errors in either long wait therefore show up, and so does merging the reset release with the reference select. It sends stray stop and start pulses into the reset wait, the settle wait, the shutdown steps, the idle state and the ready state. A design that acted on any of them would show an unexpected edge or lose its reset too early. Runs with and without a crystal, and a restart after power-down, catch a pad select stuck at one value and a power-down bit that is not cleared on restart.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

   // bit positions in the exported control word; the PHY decodes these
   localparam int unsigned POS_REFPAD = 28;
   localparam int unsigned POS_PWRDN  = 27;
   localparam int unsigned POS_LANE   = 24;
   localparam int unsigned POS_EN     = 8;
   localparam int unsigned POS_RST    = 7;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_RST,
      ST_REFSEL,
      ST_SETTLE,
      ST_ON,
      ST_DROP_REF,
      ST_PWRDN
   } seq_state_e;

   typedef struct packed {
      logic refpad;
      logic pwrdn;
      logic lane;
      logic en;
      logic rst;
   } phy_ctl_t;

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
   import phy_pwr_seq_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned RST_LOAD    = 1,
   parameter int unsigned SETTLE_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             xtal_present,
   input  logic             expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output phy_ctl_t         ctl,
   output logic             ready,
   output logic             busy
);

   seq_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_OFF;
         ctl   <= '0;
         ready <= 1'b0;
      end else begin
         case (state)
            ST_OFF: if (start_req) begin
               ctl.rst   <= 1'b1;
               ctl.pwrdn <= 1'b0;
               state     <= ST_RST;
            end
            ST_RST: if (expired) begin
               ctl.rst <= 1'b0;
               state   <= ST_REFSEL;
            end
            ST_REFSEL: begin
               ctl.refpad <= xtal_present;
               state      <= ST_SETTLE;
            end
            ST_SETTLE: if (expired) begin
               ctl.en   <= 1'b1;
               ctl.lane <= 1'b1;
               ready    <= 1'b1;
               state    <= ST_ON;
            end
            ST_ON: if (stop_req) begin
               ctl.en   <= 1'b0;
               ctl.lane <= 1'b0;
               ready    <= 1'b0;
               state    <= ST_DROP_REF;
            end
            ST_DROP_REF: begin
               ctl.refpad <= 1'b0;
               state      <= ST_PWRDN;
            end
            ST_PWRDN: begin
               ctl.pwrdn <= 1'b1;
               state     <= ST_OFF;
            end
            default: state <= ST_OFF;
         endcase
      end
   end

   always_comb begin
      tmr_load = (state == ST_OFF && start_req) || (state == ST_REFSEL);
      tmr_val  = (state == ST_OFF) ? CNT_W'(RST_LOAD) : CNT_W'(SETTLE_LOAD);
      busy     = (state != ST_OFF) && (state != ST_ON);
   end

endmodule

// File: rtl/seq_word_pack.sv
module seq_word_pack
   import phy_pwr_seq_pkg::*;
#(
   parameter int unsigned      WORD_W = 32,
   parameter logic [WORD_W-1:0] BASE  = '0
) (
   input  phy_ctl_t            ctl,
   output logic [WORD_W-1:0]   word
);

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == POS_REFPAD) begin : g_ref
         assign word[b] = ctl.refpad;
      end else if (b == POS_PWRDN) begin : g_pd
         assign word[b] = ctl.pwrdn;
      end else if (b == POS_LANE) begin : g_lane
         assign word[b] = ctl.lane;
      end else if (b == POS_EN) begin : g_en
         assign word[b] = ctl.en;
      end else if (b == POS_RST) begin : g_rst
         assign word[b] = ctl.rst;
      end else begin : g_const
         assign word[b] = BASE[b];
      end
   end

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
   import phy_pwr_seq_pkg::*;
#(
   parameter int unsigned       CYC_PER_US = 100,
   parameter int unsigned       RST_US     = 2000,
   parameter int unsigned       SETTLE_US  = 30000,
   parameter int unsigned       WORD_W     = 32,
   parameter logic [WORD_W-1:0] CTRL_BASE  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              xtal_present,
   output logic [WORD_W-1:0] ctrl_word,
   output logic              ready,
   output logic              busy
);

   localparam int unsigned RST_CYC    = RST_US * CYC_PER_US;
   localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
   localparam int unsigned MAX_CYC    = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
   localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
   localparam logic [WORD_W-1:0] CTL_MASK =
      (WORD_W'(1) << POS_REFPAD) | (WORD_W'(1) << POS_PWRDN) |
      (WORD_W'(1) << POS_LANE)   | (WORD_W'(1) << POS_EN)    |
      (WORD_W'(1) << POS_RST);

   if (CYC_PER_US < 1 || RST_US < 1 || SETTLE_US < 1) begin : g_bad_time
      $error("phy_pwr_seq: delay parameters must be at least 1");
   end
   if (WORD_W <= POS_REFPAD) begin : g_bad_width
      $error("phy_pwr_seq: WORD_W too narrow for the control bits");
   end
   if ((CTRL_BASE & CTL_MASK) != '0) begin : g_bad_base
      $error("phy_pwr_seq: CTRL_BASE overlaps sequencer-owned bits");
   end

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   phy_ctl_t         ctl;

   seq_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   seq_ctrl_fsm #(
      .CNT_W       (CNT_W),
      .RST_LOAD    (RST_CYC - 1),
      .SETTLE_LOAD (SETTLE_CYC - 1)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (start_req),
      .stop_req     (stop_req),
      .xtal_present (xtal_present),
      .expired      (tmr_expired),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .ctl          (ctl),
      .ready        (ready),
      .busy         (busy)
   );

   seq_word_pack #(.WORD_W(WORD_W), .BASE(CTRL_BASE)) u_pack (
      .ctl  (ctl),
      .word (ctrl_word)
   );

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk
   import phy_pwr_seq_pkg::*;
#(
   parameter int unsigned       WORD_W    = 32,
   parameter logic [WORD_W-1:0] CTRL_BASE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] word,
   input logic              ready,
   input logic              busy
);

   localparam logic [WORD_W-1:0] OWN_MASK =
      (WORD_W'(1) << POS_REFPAD) | (WORD_W'(1) << POS_PWRDN) |
      (WORD_W'(1) << POS_LANE)   | (WORD_W'(1) << POS_EN)    |
      (WORD_W'(1) << POS_RST);

   // R5
   ready_means_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (word[POS_EN] && word[POS_LANE] && !word[POS_RST] && !busy));

   // R2
   rst_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word[POS_RST] |-> (!word[POS_EN] && !word[POS_PWRDN] && busy));

   // R3
   rst_release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(word[POS_RST]) |-> ($stable(word[POS_REFPAD]) && !word[POS_EN]));

   // R4
   en_lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word[POS_EN] == word[POS_LANE]);

   // R6
   ref_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(word[POS_REFPAD]) |-> (!word[POS_EN] && $past(!word[POS_EN])));

   // R6
   pwrdn_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word[POS_PWRDN]) |-> (!word[POS_REFPAD] && $past(!word[POS_REFPAD]) && !busy));

   // R8
   base_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word & ~OWN_MASK) == (CTRL_BASE & ~OWN_MASK));

endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(
   .WORD_W    (WORD_W),
   .CTRL_BASE (CTRL_BASE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .word  (ctrl_word),
   .ready (ready),
   .busy  (busy)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

   localparam int unsigned CYC    = 2;
   localparam int unsigned RUS    = 5;
   localparam int unsigned SUS    = 8;
   localparam int          R      = RUS * CYC;
   localparam int          S      = SUS * CYC;
   localparam logic [31:0] BASE   = 32'h0000_0070;
   localparam logic [31:0] MASK   = 32'h1900_0180;

   logic        clk = 1'b0;
   logic        rst_n, start_req, stop_req, xtal_present;
   logic [31:0] ctrl_word;
   logic        ready, busy;

   phy_pwr_seq #(
      .CYC_PER_US (CYC),
      .RST_US     (RUS),
      .SETTLE_US  (SUS),
      .WORD_W     (32),
      .CTRL_BASE  (BASE)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (start_req),
      .stop_req     (stop_req),
      .xtal_present (xtal_present),
      .ctrl_word    (ctrl_word),
      .ready        (ready),
      .busy         (busy)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int          at;
      logic [33:0] key;
      string       tag;
   } exp_t;

   exp_t        q[$];
   exp_t        it;
   logic [33:0] last_key;
   logic [33:0] prev;
   logic [33:0] cur;
   logic        mon_en = 1'b0;

   logic m_rst = 0, m_ref = 0, m_pd = 0, m_lane = 0, m_en = 0, m_ready = 0, m_busy = 0;

   function automatic logic [31:0] mk();
      logic [31:0] w;
      w     = BASE;
      w[28] = m_ref;
      w[27] = m_pd;
      w[24] = m_lane;
      w[8]  = m_en;
      w[7]  = m_rst;
      return w;
   endfunction

   task automatic chk(input string tag, input logic ok,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard: queue the change only if the model moved
   task automatic push(input int at, input string tag);
      exp_t e;
      logic [33:0] k;
      k = {m_ready, m_busy, mk()};
      if (k !== last_key) begin
         e.at = at; e.key = k; e.tag = tag;
         q.push_back(e);
         last_key = k;
      end
   endtask

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
   endtask

   int done_at;

   task automatic do_start(input logic x);
      int c;
      xtal_present = x;
      c = cyc;
      start_req = 1'b1;
      m_rst = 1; m_pd = 0; m_busy = 1;           push(c + 1, "R2");
      m_rst = 0;                                  push(c + 1 + R, "R2 R3");
      m_ref = x;                                  push(c + 2 + R, "R3");
      m_en = 1; m_lane = 1; m_ready = 1; m_busy = 0;
      push(c + 2 + R + S, "R4 R5");
      done_at = c + 2 + R + S;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic do_stop();
      int c;
      c = cyc;
      stop_req = 1'b1;
      m_en = 0; m_lane = 0; m_ready = 0; m_busy = 1; push(c + 1, "R6");
      m_ref = 0;                                   push(c + 2, "R6");
      m_pd = 1; m_busy = 0;                        push(c + 3, "R6");
      done_at = c + 3;
      @(negedge clk);
      stop_req = 1'b0;
   endtask

   task automatic snap(input string tag);
      logic [33:0] k;
      k = {ready, busy, ctrl_word};
      chk(tag, k === last_key, {30'd0, k}, {30'd0, last_key});
   endtask

   // monitor side: every output change must match the head of the queue
   always @(negedge clk) begin
      if (mon_en) begin
         cur = {ready, busy, ctrl_word};
         if (cur !== prev) begin
            chk("R8", (ctrl_word & ~MASK) === (BASE & ~MASK),
                {32'd0, ctrl_word & ~MASK}, {32'd0, BASE & ~MASK});
            if (q.size() == 0) begin
               chk("R7 unexpected change", 1'b0, {30'd0, cur}, {30'd0, prev});
            end else begin
               it = q.pop_front();
               chk(it.tag, (cur === it.key) && (cyc == it.at),
                   {cyc[29:0], cur}, {it.at[29:0], it.key});
            end
            prev = cur;
         end
      end
   end

   initial begin
      rst_n = 1'b0; start_req = 1'b0; stop_req = 1'b0; xtal_present = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      chk("R1", ctrl_word === BASE && ready === 1'b0 && busy === 1'b0,
          {30'd0, ready, busy, ctrl_word}, {32'd0, BASE});
      last_key = {1'b0, 1'b0, BASE};
      prev     = last_key;
      mon_en   = 1'b1;
      @(negedge clk);

      // run 1: crystal present, stray requests during both waits (R7)
      begin
         int c0;
         c0 = cyc;
         do_start(1'b1);
         wait_until(c0 + 4);
         pulse_stop();
         wait_until(c0 + 2 + R + 4);
         pulse_start();
         wait_until(done_at + 2);
         snap("R7 busy requests ignored");
      end

      // start while ready is ignored (R7)
      pulse_start();
      repeat (3) @(negedge clk);
      snap("R7 start while ready");

      // shutdown with a stray start in the middle (R6, R7)
      begin
         int c1;
         c1 = cyc;
         do_stop();
         wait_until(c1 + 1);
         pulse_start();
         wait_until(done_at + 2);
         snap("R6 R7 off after stop");
      end

      // stop while idle is ignored (R7)
      pulse_stop();
      repeat (3) @(negedge clk);
      snap("R7 stop while idle");

      // run 2: no crystal, restart clears power-down (R2, R3)
      do_start(1'b0);
      wait_until(done_at + 2);
      snap("R3 no crystal up");
      do_stop();
      wait_until(done_at + 2);

      // run 3: crystal again after power-down
      do_start(1'b1);
      wait_until(done_at + 2);
      snap("R4 restart up");
      do_stop();
      wait_until(done_at + 4);

      chk("R6 R7 all expected changes seen", q.size() == 0,
          64'(q.size()), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule